// File: doc/BRIEF.md
# GPIO Register Interface

This block is a memory-mapped slave for a general-purpose pin controller. It accepts single-beat reads and writes on an AXI4-Lite port and keeps the control words a pin controller needs. These are the pin direction, the driven level with atomic set and clear aliases, the interrupt enable and trigger selection words, a filter threshold, a scratch word and a fixed identification word. Every write honours its byte strobes. Pins drive only where the direction word marks them as outputs.

Input synchronisation, glitch filtering and interrupt generation live in neighbouring blocks. This block reads their results through the `pin_sample_i` and `int_pending_i` ports. It hands them their configuration through the `*_o` configuration ports. A write to the acknowledge offset produces a one-cycle pulse on `int_ack_o`.

Two state machines run side by side.

The write machine has five states:
- WR_IDLE: both address and data ready.
- WR_ADDR_HELD: the address is captured and the machine waits for data.
- WR_DATA_HELD: the data is captured and the machine waits for the address.
- WR_COMMIT: one cycle in which the register is updated.
- WR_RESP: the response is valid.

The write machine's transitions:
- WR_IDLE goes to WR_COMMIT on address and data together, to WR_ADDR_HELD on address alone, and to WR_DATA_HELD on data alone.
- Each held state goes to WR_COMMIT when the missing half arrives.
- WR_COMMIT always goes to WR_RESP.
- WR_RESP returns to WR_IDLE when the response is accepted.

The read machine has two states. RD_IDLE (address ready) goes to RD_RESP when a read address is accepted, capturing the read word at that edge. RD_RESP returns to RD_IDLE when the response is accepted.

Top module: `gpio_axil_regs`

## Requirements
- R1: After reset, all writable words read zero, `pin_drive_o` and every configuration output are zero, `s_bvalid` and `s_rvalid` are low, and `s_awready`, `s_wready` and `s_arready` are high.
- R2: Write address and write data may be accepted together or in either order. A write changes no register until both have been accepted. Each write gets exactly one response, with `s_bresp` = 2'b00, held until `s_bready`, and no new write is accepted while it is pending.
- R3: Each read gets one response, with `s_rresp` = 2'b00. `s_rvalid` and `s_rdata` hold steady while `s_rready` is low.
- R4: Strobe bit b enables write-data bits [8b+7:8b]. Bytes whose strobe bit is clear keep their old value.
- R5: A write to offset 0x08 sets the level-word bits where the strobed data is 1. A write to 0x0C clears the level-word bits where the strobed data is 1. All other level bits are unchanged, and both offsets read as zero.
- R6: `pin_drive_o` equals the level word (0x04) ANDed bitwise with the direction word (0x00), where a 1 in the direction word marks an output.
- R7: Offset 0x10 reads `pin_sample_i` and offset 0x18 reads `int_pending_i`. Writes to either offset are ignored.
- R8: Offset 0x2C reads the `VERSION_ID` parameter and ignores writes. Offset 0x30 is a full 32-bit read/write word.
- R9: Offsets 0x14, 0x20, 0x24 and 0x28 are read/write words that drive `int_enable_o`, `trig_edge_o`, `edge_sense_o` and `level_sense_o`. Offset 0x34 is a `FILT_W`-bit read/write word that drives `filter_cycles_o`.
- R10: A write to offset 0x1C drives its strobed data onto `int_ack_o` for exactly one cycle, the cycle after the commit, and stores nothing; the offset reads as zero.
- R11: Offsets above 0x34, including any address with a bit set at position 6 or above, read zero and ignore writes. Bits at or above `N` in the pin-wide words read zero.
- R12: When a read address is accepted on the same edge as a write commits to the same word, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| pin_sample_i | input | N | Synchronised pin levels from the input stage |
| int_pending_i | input | N | Pending interrupt bits from the interrupt stage |
| pin_drive_o | output | N | Pin output levels, gated by direction |
| int_enable_o | output | N | Interrupt enable word |
| trig_edge_o | output | N | Edge (1) or level (0) trigger select |
| edge_sense_o | output | N | Edge sense: rising (1) or falling (0) |
| level_sense_o | output | N | Level sense: high (1) or low (0) |
| filter_cycles_o | output | FILT_W | Filter threshold in cycles |
| int_ack_o | output | N | One-cycle acknowledge pulse |

## Verification
The write commit and the read capture can fall on the same clock edge, because the two machines run independently. The bench provokes this by raising the read address in the WR_COMMIT cycle of a scratch-word write. It judges the returned word against the value from before the write, then reads again to see the new value. A second overlap is a set or clear alias landing on a level word that is already partly set. This is judged by the untouched bits on `pin_drive_o`.

// File: rtl/gpio_axil_pkg.sv
package gpio_axil_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int IDX_W  = 4;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // word index = byte offset / 4; these positions are software visible
    localparam logic [IDX_W-1:0] IDX_PIN_DIR     = 4'd0;
    localparam logic [IDX_W-1:0] IDX_PIN_LEVEL   = 4'd1;
    localparam logic [IDX_W-1:0] IDX_LEVEL_SET   = 4'd2;
    localparam logic [IDX_W-1:0] IDX_LEVEL_CLR   = 4'd3;
    localparam logic [IDX_W-1:0] IDX_PIN_SAMPLE  = 4'd4;
    localparam logic [IDX_W-1:0] IDX_INT_ENABLE  = 4'd5;
    localparam logic [IDX_W-1:0] IDX_INT_PENDING = 4'd6;
    localparam logic [IDX_W-1:0] IDX_INT_ACK     = 4'd7;
    localparam logic [IDX_W-1:0] IDX_TRIG_EDGE   = 4'd8;
    localparam logic [IDX_W-1:0] IDX_EDGE_SENSE  = 4'd9;
    localparam logic [IDX_W-1:0] IDX_LEVEL_SENSE = 4'd10;
    localparam logic [IDX_W-1:0] IDX_ID          = 4'd11;
    localparam logic [IDX_W-1:0] IDX_SPARE       = 4'd12;
    localparam logic [IDX_W-1:0] IDX_FILTER      = 4'd13;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_ADDR_HELD,
        WR_DATA_HELD,
        WR_COMMIT,
        WR_RESP
    } wr_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;

    function automatic logic [DATA_W-1:0] strobe_mask(input logic [STRB_W-1:0] s);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < STRB_W; b++) begin
            m[b*8 +: 8] = {8{s[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_axil_wr.sv
module gpio_axil_wr
    import gpio_axil_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    output logic              commit_o,
    output logic [ADDR_W-1:0] commit_addr_o,
    output logic [DATA_W-1:0] commit_data_o,
    output logic [STRB_W-1:0] commit_strb_o
);

    wr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (s_awvalid && s_wvalid) state_d = WR_COMMIT;
                else if (s_awvalid)        state_d = WR_ADDR_HELD;
                else if (s_wvalid)         state_d = WR_DATA_HELD;
            end
            WR_ADDR_HELD: if (s_wvalid)  state_d = WR_COMMIT;
            WR_DATA_HELD: if (s_awvalid) state_d = WR_COMMIT;
            WR_COMMIT:                   state_d = WR_RESP;
            WR_RESP:      if (s_bready)  state_d = WR_IDLE;
            default:                     state_d = WR_IDLE;
        endcase
    end

    // outputs decoded from the state alone
    always_comb begin
        s_awready = (state_q == WR_IDLE) || (state_q == WR_DATA_HELD);
        s_wready  = (state_q == WR_IDLE) || (state_q == WR_ADDR_HELD);
        s_bvalid  = (state_q == WR_RESP);
        s_bresp   = RESP_OKAY;
        commit_o  = (state_q == WR_COMMIT);
    end

    // payload capture on each handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
        end else begin
            if (s_awvalid && s_awready) addr_q <= s_awaddr;
            if (s_wvalid && s_wready) begin
                data_q <= s_wdata;
                strb_q <= s_wstrb;
            end
        end
    end

    assign commit_addr_o = addr_q;
    assign commit_data_o = data_q;
    assign commit_strb_o = strb_q;

endmodule

// File: rtl/gpio_axil_rd.sv
module gpio_axil_rd
    import gpio_axil_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic [ADDR_W-1:0] look_addr_o,
    input  logic [DATA_W-1:0] look_word_i
);

    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (s_arvalid) state_d = RD_RESP;
            RD_RESP: if (s_rready)  state_d = RD_IDLE;
            default:                state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        s_arready = (state_q == RD_IDLE);
        s_rvalid  = (state_q == RD_RESP);
        s_rresp   = RESP_OKAY;
    end

    // the word is frozen at the address handshake so it stays stable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (s_arvalid && s_arready) begin
            data_q <= look_word_i;
        end
    end

    assign look_addr_o = s_araddr;
    assign s_rdata     = data_q;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_axil_pkg::*;
#(
    parameter int          N          = 32,
    parameter int          FILT_W     = 16,
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] VERSION_ID = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STRB_W-1:0] wstrb_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rword_o,
    input  logic [N-1:0]      pin_sample_i,
    input  logic [N-1:0]      int_pending_i,
    output logic [N-1:0]      pin_dir_o,
    output logic [N-1:0]      pin_level_o,
    output logic [N-1:0]      int_enable_o,
    output logic [N-1:0]      trig_edge_o,
    output logic [N-1:0]      edge_sense_o,
    output logic [N-1:0]      level_sense_o,
    output logic [FILT_W-1:0] filter_cycles_o,
    output logic [N-1:0]      int_ack_o
);

    logic [N-1:0]      dir_q, level_q, ien_q, trig_q, esense_q, lsense_q, ack_q;
    logic [DATA_W-1:0] spare_q;
    logic [FILT_W-1:0] filt_q;

    logic [DATA_W-1:0] bmask;
    logic [N-1:0]      wbits;
    logic              w_hit, r_hit;
    logic [IDX_W-1:0]  w_idx, r_idx;

    function automatic logic map_hit(input logic [ADDR_W-1:0] a);
        return ((a >> 6) == {ADDR_W{1'b0}}) && (a[5:2] <= IDX_FILTER);
    endfunction

    function automatic logic [DATA_W-1:0] widen_pin(input logic [N-1:0] x);
        logic [DATA_W-1:0] r;
        r = '0;
        r[N-1:0] = x;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] widen_filt(input logic [FILT_W-1:0] x);
        logic [DATA_W-1:0] r;
        r = '0;
        r[FILT_W-1:0] = x;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                                input logic [DATA_W-1:0] nu,
                                                input logic [DATA_W-1:0] m);
        return (old & ~m) | (nu & m);
    endfunction

    function automatic logic [N-1:0] to_pin(input logic [DATA_W-1:0] x);
        return x[N-1:0];
    endfunction

    assign bmask = strobe_mask(wstrb_i);
    assign wbits = to_pin(wdata_i & bmask);
    assign w_hit = map_hit(waddr_i);
    assign w_idx = waddr_i[5:2];
    assign r_hit = map_hit(raddr_i);
    assign r_idx = raddr_i[5:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            level_q  <= '0;
            ien_q    <= '0;
            trig_q   <= '0;
            esense_q <= '0;
            lsense_q <= '0;
            ack_q    <= '0;
            spare_q  <= '0;
            filt_q   <= '0;
        end else begin
            ack_q <= '0;
            if (we_i && w_hit) begin
                case (w_idx)
                    IDX_PIN_DIR:     dir_q    <= to_pin(merge(widen_pin(dir_q), wdata_i, bmask));
                    IDX_PIN_LEVEL:   level_q  <= to_pin(merge(widen_pin(level_q), wdata_i, bmask));
                    IDX_LEVEL_SET:   level_q  <= level_q | wbits;
                    IDX_LEVEL_CLR:   level_q  <= level_q & ~wbits;
                    IDX_INT_ENABLE:  ien_q    <= to_pin(merge(widen_pin(ien_q), wdata_i, bmask));
                    IDX_INT_ACK:     ack_q    <= wbits;
                    IDX_TRIG_EDGE:   trig_q   <= to_pin(merge(widen_pin(trig_q), wdata_i, bmask));
                    IDX_EDGE_SENSE:  esense_q <= to_pin(merge(widen_pin(esense_q), wdata_i, bmask));
                    IDX_LEVEL_SENSE: lsense_q <= to_pin(merge(widen_pin(lsense_q), wdata_i, bmask));
                    IDX_SPARE:       spare_q  <= merge(spare_q, wdata_i, bmask);
                    IDX_FILTER: begin
                        logic [DATA_W-1:0] f;
                        f = merge(widen_filt(filt_q), wdata_i, bmask);
                        filt_q <= f[FILT_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rword_o = '0;
        if (r_hit) begin
            case (r_idx)
                IDX_PIN_DIR:     rword_o = widen_pin(dir_q);
                IDX_PIN_LEVEL:   rword_o = widen_pin(level_q);
                IDX_PIN_SAMPLE:  rword_o = widen_pin(pin_sample_i);
                IDX_INT_ENABLE:  rword_o = widen_pin(ien_q);
                IDX_INT_PENDING: rword_o = widen_pin(int_pending_i);
                IDX_TRIG_EDGE:   rword_o = widen_pin(trig_q);
                IDX_EDGE_SENSE:  rword_o = widen_pin(esense_q);
                IDX_LEVEL_SENSE: rword_o = widen_pin(lsense_q);
                IDX_ID:          rword_o = VERSION_ID;
                IDX_SPARE:       rword_o = spare_q;
                IDX_FILTER:      rword_o = widen_filt(filt_q);
                default:         rword_o = '0;
            endcase
        end
    end

    assign pin_dir_o       = dir_q;
    assign pin_level_o     = level_q;
    assign int_enable_o    = ien_q;
    assign trig_edge_o     = trig_q;
    assign edge_sense_o    = esense_q;
    assign level_sense_o   = lsense_q;
    assign filter_cycles_o = filt_q;
    assign int_ack_o       = ack_q;

endmodule

// File: rtl/gpio_axil_regs.sv
module gpio_axil_regs
    import gpio_axil_pkg::*;
#(
    parameter int          N          = 32,
    parameter int          FILT_W     = 16,
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] VERSION_ID = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    input  logic [N-1:0]      pin_sample_i,
    input  logic [N-1:0]      int_pending_i,
    output logic [N-1:0]      pin_drive_o,
    output logic [N-1:0]      int_enable_o,
    output logic [N-1:0]      trig_edge_o,
    output logic [N-1:0]      edge_sense_o,
    output logic [N-1:0]      level_sense_o,
    output logic [FILT_W-1:0] filter_cycles_o,
    output logic [N-1:0]      int_ack_o
);

    logic              commit;
    logic [ADDR_W-1:0] commit_addr, look_addr;
    logic [DATA_W-1:0] commit_data, look_word;
    logic [STRB_W-1:0] commit_strb;
    logic [N-1:0]      pin_dir, pin_level;

    gpio_axil_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .s_awvalid     (s_awvalid),
        .s_awready     (s_awready),
        .s_awaddr      (s_awaddr),
        .s_wvalid      (s_wvalid),
        .s_wready      (s_wready),
        .s_wdata       (s_wdata),
        .s_wstrb       (s_wstrb),
        .s_bvalid      (s_bvalid),
        .s_bready      (s_bready),
        .s_bresp       (s_bresp),
        .commit_o      (commit),
        .commit_addr_o (commit_addr),
        .commit_data_o (commit_data),
        .commit_strb_o (commit_strb)
    );

    gpio_axil_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_arvalid   (s_arvalid),
        .s_arready   (s_arready),
        .s_araddr    (s_araddr),
        .s_rvalid    (s_rvalid),
        .s_rready    (s_rready),
        .s_rdata     (s_rdata),
        .s_rresp     (s_rresp),
        .look_addr_o (look_addr),
        .look_word_i (look_word)
    );

    gpio_regfile #(
        .N          (N),
        .FILT_W     (FILT_W),
        .ADDR_W     (ADDR_W),
        .VERSION_ID (VERSION_ID)
    ) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .we_i            (commit),
        .waddr_i         (commit_addr),
        .wdata_i         (commit_data),
        .wstrb_i         (commit_strb),
        .raddr_i         (look_addr),
        .rword_o         (look_word),
        .pin_sample_i    (pin_sample_i),
        .int_pending_i   (int_pending_i),
        .pin_dir_o       (pin_dir),
        .pin_level_o     (pin_level),
        .int_enable_o    (int_enable_o),
        .trig_edge_o     (trig_edge_o),
        .edge_sense_o    (edge_sense_o),
        .level_sense_o   (level_sense_o),
        .filter_cycles_o (filter_cycles_o),
        .int_ack_o       (int_ack_o)
    );

    // only pins marked as outputs drive their level
    assign pin_drive_o = pin_level & pin_dir;

endmodule

// File: rtl/gpio_axil_regs_chk.sv
module gpio_axil_regs_chk
    import gpio_axil_pkg::*;
#(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         s_awready,
    input logic         s_wready,
    input logic         s_bvalid,
    input logic         s_bready,
    input logic [1:0]   s_bresp,
    input logic         s_arready,
    input logic         s_rvalid,
    input logic         s_rready,
    input logic [31:0]  s_rdata,
    input logic [1:0]   s_rresp,
    input logic [N-1:0] int_ack_o
);

    AST_B_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> s_bresp == RESP_OKAY); // R2

    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid); // R2

    AST_B_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && s_bready |=> !s_bvalid); // R2

    AST_NO_WRITE_WHILE_B: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !s_awready && !s_wready); // R2

    AST_R_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> s_rresp == RESP_OKAY); // R3

    AST_R_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R3

    AST_R_NO_NEW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_arready); // R3

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack_o != '0) |=> (int_ack_o == '0)); // R10

endmodule

bind gpio_axil_regs gpio_axil_regs_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_awready (s_awready),
    .s_wready  (s_wready),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_bresp   (s_bresp),
    .s_arready (s_arready),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp),
    .int_ack_o (int_ack_o)
);

// File: tb/test_gpio_axil_regs.sv
module test_gpio_axil_regs;

    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 12;
    localparam int          FILT_W     = 16;
    localparam int          ADDR_W     = 8;
    localparam logic [31:0] VER        = 32'hA5C3_0102;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_awvalid = 1'b0, s_awready;
    logic [ADDR_W-1:0] s_awaddr = '0;
    logic              s_wvalid = 1'b0, s_wready;
    logic [31:0]       s_wdata = '0;
    logic [3:0]        s_wstrb = '0;
    logic              s_bvalid, s_bready = 1'b0;
    logic [1:0]        s_bresp;
    logic              s_arvalid = 1'b0, s_arready;
    logic [ADDR_W-1:0] s_araddr = '0;
    logic              s_rvalid, s_rready = 1'b0;
    logic [31:0]       s_rdata;
    logic [1:0]        s_rresp;
    logic [N-1:0]      pin_sample_i = '0, int_pending_i = '0;
    logic [N-1:0]      pin_drive_o, int_enable_o, trig_edge_o, edge_sense_o, level_sense_o, int_ack_o;
    logic [FILT_W-1:0] filter_cycles_o;

    int n_tests = 0;
    int n_fail  = 0;
    int ack_hits = 0;
    logic [N-1:0] ack_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_axil_regs #(.N(N), .FILT_W(FILT_W), .ADDR_W(ADDR_W), .VERSION_ID(VER)) i_gpio_axil_regs (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .pin_sample_i(pin_sample_i), .int_pending_i(int_pending_i),
        .pin_drive_o(pin_drive_o), .int_enable_o(int_enable_o), .trig_edge_o(trig_edge_o),
        .edge_sense_o(edge_sense_o), .level_sense_o(level_sense_o),
        .filter_cycles_o(filter_cycles_o), .int_ack_o(int_ack_o)
    );

    always @(negedge clk) begin
        if (int_ack_o != '0) begin
            ack_hits++;
            ack_val = int_ack_o;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // order: 0 address and data together, 1 address first, 2 data first
    task automatic axi_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] s, input int order);
        logic [N-1:0] snap;
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = s;
        if (order == 0) begin
            s_awvalid = 1'b1; s_wvalid = 1'b1;
            @(negedge clk);
            s_awvalid = 1'b0; s_wvalid = 1'b0;
        end else begin
            snap = pin_drive_o;
            if (order == 1) s_awvalid = 1'b1; else s_wvalid = 1'b1;
            @(negedge clk);
            s_awvalid = 1'b0; s_wvalid = 1'b0;
            repeat (2) @(negedge clk);
            chk("R2 no response before both halves", 32'(s_bvalid), 32'd0);
            chk("R2 no commit before both halves", 32'(pin_drive_o), 32'(snap));
            if (order == 1) s_wvalid = 1'b1; else s_awvalid = 1'b1;
            @(negedge clk);
            s_awvalid = 1'b0; s_wvalid = 1'b0;
        end
        while (!s_bvalid) @(negedge clk);
        chk("R2 bresp okay", 32'(s_bresp), 32'd0);
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
        chk("R2 single response", 32'(s_bvalid), 32'd0);
    endtask

    task automatic axi_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        @(negedge clk);
        s_arvalid = 1'b0;
        while (!s_rvalid) @(negedge clk);
        d = s_rdata;
        chk("R3 rresp okay", 32'(s_rresp), 32'd0);
        repeat (2) @(negedge clk);
        chk("R3 rdata held while not ready", s_rdata, d);
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
        chk("R3 rvalid drops after accept", 32'(s_rvalid), 32'd0);
    endtask

    task automatic expect_read(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        axi_read(a, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        chk("R1 awready", 32'(s_awready), 32'd1);
        chk("R1 wready", 32'(s_wready), 32'd1);
        chk("R1 arready", 32'(s_arready), 32'd1);
        chk("R1 bvalid", 32'(s_bvalid), 32'd0);
        chk("R1 rvalid", 32'(s_rvalid), 32'd0);
        chk("R1 pin_drive", 32'(pin_drive_o), 32'd0);
        chk("R1 filter", 32'(filter_cycles_o), 32'd0);
        expect_read("R1 dir", 8'h00, 32'd0);
        expect_read("R1 level", 8'h04, 32'd0);
        expect_read("R1 spare", 8'h30, 32'd0);
    endtask

    task automatic t_order();
        axi_write(8'h00, 32'h0000_0FFF, 4'hF, 0);
        axi_write(8'h04, 32'h0000_0123, 4'hF, 1);
        chk("R2 address-first write lands", 32'(pin_drive_o), 32'h123);
        axi_write(8'h04, 32'h0000_0456, 4'hF, 2);
        chk("R2 data-first write lands", 32'(pin_drive_o), 32'h456);
        expect_read("R2 level readback", 8'h04, 32'h456);
    endtask

    task automatic t_strobe();
        axi_write(8'h30, 32'hFFFF_FFFF, 4'hF, 0);
        axi_write(8'h30, 32'h00AB_0000, 4'b0100, 0);
        expect_read("R4 only byte 2 changes", 8'h30, 32'hFFAB_FFFF);
        axi_write(8'h00, 32'h0000_0000, 4'hF, 0);
        axi_write(8'h00, 32'h0000_0FFF, 4'b0001, 2);
        expect_read("R4 dir low byte only", 8'h00, 32'h0000_00FF);
    endtask

    task automatic t_set_clr();
        axi_write(8'h00, 32'h0000_0FFF, 4'hF, 0);
        axi_write(8'h04, 32'h0000_00F0, 4'hF, 0);
        axi_write(8'h08, 32'h0000_000F, 4'hF, 0);
        chk("R5 set keeps other bits", 32'(pin_drive_o), 32'h0FF);
        axi_write(8'h0C, 32'h0000_00F0, 4'hF, 1);
        chk("R5 clear keeps other bits", 32'(pin_drive_o), 32'h00F);
        axi_write(8'h08, 32'h0000_0F00, 4'b0001, 0);
        chk("R5 set honours strobe", 32'(pin_drive_o), 32'h00F);
        expect_read("R5 set alias reads zero", 8'h08, 32'd0);
        expect_read("R5 clear alias reads zero", 8'h0C, 32'd0);
    endtask

    task automatic t_gate();
        axi_write(8'h04, 32'h0000_0FF0, 4'hF, 0);
        axi_write(8'h00, 32'h0000_0F3C, 4'hF, 0);
        chk("R6 drive gated by direction", 32'(pin_drive_o), 32'h0F30);
        axi_write(8'h00, 32'h0000_0000, 4'hF, 0);
        chk("R6 all inputs drive nothing", 32'(pin_drive_o), 32'h0);
    endtask

    task automatic t_inputs();
        pin_sample_i = 12'hABC;
        int_pending_i = 12'h123;
        expect_read("R7 sample view", 8'h10, 32'h0000_0ABC);
        axi_write(8'h10, 32'h0000_0000, 4'hF, 0);
        expect_read("R7 sample ignores write", 8'h10, 32'h0000_0ABC);
        axi_write(8'h18, 32'h0000_0000, 4'hF, 0);
        expect_read("R7 pending view", 8'h18, 32'h0000_0123);
    endtask

    task automatic t_id_spare();
        expect_read("R8 id word", 8'h2C, VER);
        axi_write(8'h2C, 32'h0, 4'hF, 0);
        expect_read("R8 id ignores write", 8'h2C, VER);
        axi_write(8'h30, 32'h1357_9BDF, 4'hF, 2);
        expect_read("R8 spare full width", 8'h30, 32'h1357_9BDF);
    endtask

    task automatic t_config();
        axi_write(8'h14, 32'hFFFF_FFFF, 4'hF, 0);
        chk("R9 enable output", 32'(int_enable_o), 32'h0FFF);
        expect_read("R11 bits above N read zero", 8'h14, 32'h0000_0FFF);
        axi_write(8'h20, 32'h0000_0A0A, 4'hF, 0);
        axi_write(8'h24, 32'h0000_0B0B, 4'hF, 0);
        axi_write(8'h28, 32'h0000_0C0C, 4'hF, 0);
        chk("R9 trigger select", 32'(trig_edge_o), 32'h0A0A);
        chk("R9 edge sense", 32'(edge_sense_o), 32'h0B0B);
        chk("R9 level sense", 32'(level_sense_o), 32'h0C0C);
        axi_write(8'h34, 32'h1234_5678, 4'hF, 0);
        chk("R9 filter output", 32'(filter_cycles_o), 32'h5678);
        expect_read("R9 filter readback", 8'h34, 32'h0000_5678);
    endtask

    task automatic t_ack();
        ack_hits = 0;
        axi_write(8'h1C, 32'h0000_00A5, 4'hF, 0);
        repeat (3) @(negedge clk);
        chk("R10 one pulse", 32'(ack_hits), 32'd1);
        chk("R10 pulse value", 32'(ack_val), 32'h0A5);
        expect_read("R10 ack reads zero", 8'h1C, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        expect_read("R11 offset 0x38 reads zero", 8'h38, 32'd0);
        expect_read("R11 offset 0xFC reads zero", 8'hFC, 32'd0);
        axi_read(8'h30, d);
        axi_write(8'h38, 32'hDEAD_BEEF, 4'hF, 0);
        expect_read("R11 unmapped write ignored", 8'h30, d);
        axi_write(8'h00, 32'h0000_0055, 4'hF, 0);
        axi_write(8'h80, 32'h0000_0FFF, 4'hF, 0);
        expect_read("R11 high address bit does not alias", 8'h00, 32'h0000_0055);
    endtask

    task automatic t_same_edge();
        axi_write(8'h30, 32'h1111_1111, 4'hF, 0);
        @(negedge clk);
        s_awaddr = 8'h30; s_wdata = 32'h2222_2222; s_wstrb = 4'hF;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        s_araddr = 8'h30; s_arvalid = 1'b1;
        @(negedge clk);
        s_arvalid = 1'b0;
        chk("R12 read and write both pending", {30'd0, s_rvalid, s_bvalid}, 32'd3);
        chk("R12 read sees pre-write word", s_rdata, 32'h1111_1111);
        s_rready = 1'b1; s_bready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0; s_bready = 1'b0;
        expect_read("R12 next read sees new word", 8'h30, 32'h2222_2222);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_strobe();
        t_set_clr();
        t_gate();
        t_inputs();
        t_id_spare();
        t_config();
        t_ack();
        t_unmapped();
        t_same_edge();
        finish_run();
    end

endmodule